// File: doc/BRIEF.md
# Packed Lane Adder with Greater-or-Equal Flags

This block is a registered SIMD datapath for a 32-bit word. It adds or subtracts two operands either as four independent 8-bit lanes or as two independent 16-bit lanes, in unsigned or signed form. Each lane's result is the wrapped low part of the exact answer. Each lane also produces a greater-or-equal condition, and that condition is stored in a 4-bit flag register.

A later pick operation uses the stored flags to assemble a word byte by byte from the two operands. A flag-load operation writes the flag register directly. Operations are issued with a single valid strobe. The packed result and the flag register are both registered outputs, and they change on the clock edge at which valid is high.

The operation code is decoded into four kinds: arithmetic, pick, flag load and idle. The kinds are selected with a unique case in the next-state logic.

Top module: `simd_ge_alu`

## Requirements
- R1: While `rst_n` is low and after it is released, `result_o` and `ge_o` read zero until the first accepted operation.
- R2: `op_i` codes are 0 add8u, 1 sub8u, 2 add16u, 3 sub16u, 4 add8s, 5 sub8s, 6 add16s, 7 sub16s, 8 pick, 9 flag load, and 10 to 15 reserved. For codes 0, 1, 4 and 5, byte lane k of `result_o` (bits 8k+7:8k) equals the lane sum or difference taken modulo 2^8, one cycle after the valid edge.
- R3: For codes 2, 3, 6 and 7, halfword lane h of `result_o` (bits 16h+15:16h) equals the lane sum or difference taken modulo 2^16.
- R4: For unsigned addition (codes 0 and 2), a lane's flag is 1 exactly when the true lane sum is at least 2^8 or 2^16 respectively.
- R5: For unsigned subtraction (codes 1 and 3), a lane's flag is 1 exactly when the A lane is greater than or equal to the B lane.
- R6: For signed addition and subtraction (codes 4 to 7), a lane's flag is 1 exactly when the exact result is zero or positive, even when the wrapped result overflows.
- R7: Byte operations write `ge_o[k]` from byte lane k. Halfword operations write both `ge_o[3]` and `ge_o[2]` from the upper halfword, and both `ge_o[1]` and `ge_o[0]` from the lower halfword.
- R8: Pick (code 8) sets result byte k to A byte k when `ge_o[k]` held 1 before the edge, and to B byte k otherwise. Pick leaves `ge_o` unchanged.
- R9: Flag load (code 9) copies `a_i[3:0]` into `ge_o` and leaves `result_o` unchanged.
- R10: When `valid_i` is low, or `op_i` is a reserved code, `result_o` and `ge_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the operation on this edge |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | Registered packed result |
| ge_o | output | 4 | Registered greater-or-equal flags |

## Verification
The flag register is the only state that carries over from one operation to the next. A wrong flag therefore shows at `ge_o` one cycle after the operation that wrote it. It shows again in `result_o` one cycle after the next pick, where whole bytes come from the wrong operand. Result lanes carry no state, so a fault in a carry split or a lane boundary appears at `result_o` in the cycle right after the faulty operation. The bench runs every lane width and signedness over the 0x00/0x7F/0x80/0xFF boundary values and their halfword forms. Each of those operations is followed by a pick, so stale or mis-paired flags are exposed one cycle later.

// File: rtl/simd_ge_pkg.sv
`timescale 1ns/1ps
package simd_ge_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_PICK   = 4'd8;
    localparam logic [OP_W-1:0] OP_FLAGLD = 4'd9;

    typedef enum logic [1:0] {
        K_IDLE,
        K_ARITH,
        K_PICK,
        K_FLAGLD
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     sub;
        logic     half;
        logic     sgn;
    } op_ctl_t;

endpackage

// File: rtl/simd_ge_decode.sv
`timescale 1ns/1ps
module simd_ge_decode
    import simd_ge_pkg::*;
(
    input  logic            valid_i,
    input  logic [OP_W-1:0] op_i,
    output op_ctl_t         ctl_o
);

    always_comb begin
        ctl_o.kind = K_IDLE;
        ctl_o.sub  = op_i[0];
        ctl_o.half = op_i[1];
        ctl_o.sgn  = op_i[2];
        if (valid_i) begin
            if (!op_i[3]) begin
                ctl_o.kind = K_ARITH;
            end else if (op_i == OP_PICK) begin
                ctl_o.kind = K_PICK;
            end else if (op_i == OP_FLAGLD) begin
                ctl_o.kind = K_FLAGLD;
            end
        end
    end

endmodule

// File: rtl/simd_lane_addsub.sv
`timescale 1ns/1ps
module simd_lane_addsub #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              sgn_i,
    output logic [LANE_W-1:0] sum_o,
    output logic              ge_o
);

    localparam int EXT_W = LANE_W + 1;

    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] b_ext;
    logic [EXT_W-1:0] raw;

    // One extra bit holds the exact sign (signed or subtract) or the carry (unsigned add).
    always_comb begin
        a_ext = {sgn_i & a_i[LANE_W-1], a_i};
        b_ext = {sgn_i & b_i[LANE_W-1], b_i};
        raw   = sub_i ? (a_ext - b_ext) : (a_ext + b_ext);
        sum_o = raw[LANE_W-1:0];
        ge_o  = (!sub_i && !sgn_i) ? raw[LANE_W] : ~raw[LANE_W];
    end

endmodule

// File: rtl/simd_ge_alu.sv
`timescale 1ns/1ps
module simd_ge_alu
    import simd_ge_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] result_o,
    output logic [3:0]        ge_o
);

    localparam int N_BYTE = WORD_W / BYTE_W;
    localparam int HALF_W = 2 * BYTE_W;
    localparam int N_HALF = WORD_W / HALF_W;

    op_ctl_t ctl;

    logic [WORD_W-1:0] byte_sum;
    logic [WORD_W-1:0] half_sum;
    logic [N_BYTE-1:0] byte_ge;
    logic [N_HALF-1:0] half_ge;
    logic [N_BYTE-1:0] half_ge_pairs;
    logic [WORD_W-1:0] pick_word;

    logic [WORD_W-1:0] res_q, res_d;
    logic [N_BYTE-1:0] ge_q, ge_d;

    simd_ge_decode u_dec (
        .valid_i (valid_i),
        .op_i    (op_i),
        .ctl_o   (ctl)
    );

    for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
        simd_lane_addsub #(.LANE_W(BYTE_W)) u_lane (
            .a_i   (a_i[k*BYTE_W +: BYTE_W]),
            .b_i   (b_i[k*BYTE_W +: BYTE_W]),
            .sub_i (ctl.sub),
            .sgn_i (ctl.sgn),
            .sum_o (byte_sum[k*BYTE_W +: BYTE_W]),
            .ge_o  (byte_ge[k])
        );
        assign pick_word[k*BYTE_W +: BYTE_W] =
            ge_q[k] ? a_i[k*BYTE_W +: BYTE_W] : b_i[k*BYTE_W +: BYTE_W];
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        simd_lane_addsub #(.LANE_W(HALF_W)) u_lane (
            .a_i   (a_i[h*HALF_W +: HALF_W]),
            .b_i   (b_i[h*HALF_W +: HALF_W]),
            .sub_i (ctl.sub),
            .sgn_i (ctl.sgn),
            .sum_o (half_sum[h*HALF_W +: HALF_W]),
            .ge_o  (half_ge[h])
        );
        assign half_ge_pairs[2*h +: 2] = {2{half_ge[h]}};
    end

    always_comb begin
        res_d = res_q;
        ge_d  = ge_q;
        unique case (ctl.kind)
            K_ARITH: begin
                res_d = ctl.half ? half_sum : byte_sum;
                ge_d  = ctl.half ? half_ge_pairs : byte_ge;
            end
            K_PICK: begin
                res_d = pick_word;
            end
            K_FLAGLD: begin
                ge_d = a_i[N_BYTE-1:0];
            end
            K_IDLE: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            ge_q  <= '0;
        end else begin
            res_q <= res_d;
            ge_q  <= ge_d;
        end
    end

    assign result_o = res_q;
    assign ge_o     = ge_q;

endmodule

// File: rtl/simd_ge_alu_chk.sv
`timescale 1ns/1ps
module simd_ge_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [3:0]  op_i,
    input logic [31:0] a_i,
    input logic [31:0] b_i,
    input logic [31:0] result_o,
    input logic [3:0]  ge_o
);

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_clear_chk: assert (result_o == 32'd0 && ge_o == 4'd0);
        end
    end

    // R10
    property p_hold;
        @(posedge clk) disable iff (!rst_n)
        (!valid_i || op_i >= 4'd10) |=> ($stable(result_o) && $stable(ge_o));
    endproperty
    hold_state_chk: assert property (p_hold);

    // R8
    property p_pick_flags;
        @(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd8) |=> $stable(ge_o);
    endproperty
    pick_keeps_flags_chk: assert property (p_pick_flags);

    // R8
    property p_pick_low_byte;
        @(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd8) |=>
            result_o[7:0] == ($past(ge_o[0]) ? $past(a_i[7:0]) : $past(b_i[7:0]));
    endproperty
    pick_byte0_chk: assert property (p_pick_low_byte);

    // R9
    property p_flag_load;
        @(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd9) |=> (ge_o == $past(a_i[3:0]) && $stable(result_o));
    endproperty
    flag_load_chk: assert property (p_flag_load);

    // R7
    property p_half_pairs;
        @(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i[3] && op_i[1]) |=> (ge_o[3] == ge_o[2] && ge_o[1] == ge_o[0]);
    endproperty
    half_pairs_chk: assert property (p_half_pairs);

    // R4
    property p_carry_flag;
        @(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd0) |=>
            ge_o[0] == (({1'b0, $past(a_i[7:0])} + {1'b0, $past(b_i[7:0])}) > 9'd255);
    endproperty
    carry_flag_chk: assert property (p_carry_flag);

    // R5
    property p_borrow_flag;
        @(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd1) |=> ge_o[3] == ($past(a_i[31:24]) >= $past(b_i[31:24]));
    endproperty
    borrow_flag_chk: assert property (p_borrow_flag);

endmodule

bind simd_ge_alu simd_ge_alu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .ge_o     (ge_o)
);

// File: tb/test_simd_ge_alu.sv
`timescale 1ns/1ps
module test_simd_ge_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [31:0] a_i = 32'd0;
    logic [31:0] b_i = 32'd0;
    logic [31:0] result_o;
    logic [3:0]  ge_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_res = 32'd0;
    logic [3:0]  exp_ge  = 4'd0;

    always #2.5 clk = ~clk;

    simd_ge_alu i_simd_ge_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .result_o (result_o),
        .ge_o     (ge_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Behavioural reference: integer lane arithmetic, one call per accepted operation.
    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        if (op < 4'd8) begin
            int  w    = op[1] ? 16 : 8;
            int  n    = 32 / w;
            longint full = longint'(1) << w;
            logic [31:0] r = '0;
            logic [3:0]  g = '0;
            for (int k = 0; k < n; k++) begin
                longint x = longint'((a >> (k*w))) & (full - 1);
                longint y = longint'((b >> (k*w))) & (full - 1);
                longint z;
                bit f;
                if (op[2]) begin
                    if (x >= full/2) x = x - full;
                    if (y >= full/2) y = y - full;
                end
                z = op[0] ? (x - y) : (x + y);
                f = (!op[0] && !op[2]) ? (z >= full) : (z >= 0);
                r = r | (32'((z % full + full) % full) << (k*w));
                if (w == 8) g[k] = f;
                else begin
                    g[2*k]   = f;
                    g[2*k+1] = f;
                end
            end
            exp_res = r;
            exp_ge  = g;
        end else if (op == 4'd8) begin
            for (int k = 0; k < 4; k++)
                exp_res[k*8 +: 8] = exp_ge[k] ? a[k*8 +: 8] : b[k*8 +: 8];
        end else if (op == 4'd9) begin
            exp_ge = a[3:0];
        end
    endtask

    function automatic string res_tag(input logic [3:0] op);
        if (op == 4'd8) return "R8";
        if (op >= 4'd9) return "R10";
        return op[1] ? "R3" : "R2";
    endfunction

    function automatic string ge_tag(input logic [3:0] op);
        string base;
        if (op == 4'd8) return "R8";
        if (op == 4'd9) return "R9";
        if (op > 4'd9) return "R10";
        base = op[2] ? "R6" : (op[0] ? "R5" : "R4");
        return op[1] ? {base, " R7"} : base;
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        valid_i = 1'b1;
        op_i    = op;
        a_i     = a;
        b_i     = b;
        model(op, a, b);
        @(negedge clk);
        valid_i = 1'b0;
        check(res_tag(op), result_o, exp_res);
        check(ge_tag(op), {28'd0, ge_o}, {28'd0, exp_ge});
    endtask

    task automatic idle_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        valid_i = 1'b0;
        op_i    = op;
        a_i     = a;
        b_i     = b;
        @(negedge clk);
        check("R10 result", result_o, exp_res);
        check("R10 flags", {28'd0, ge_o}, {28'd0, exp_ge});
    endtask

    logic [7:0]  bv [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    logic [15:0] hv [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};

    initial begin
        logic [31:0] seed = 32'h1234_5679;
        repeat (3) @(negedge clk);
        check("R1 result", result_o, 32'd0);
        check("R1 flags", {28'd0, ge_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 result", result_o, 32'd0);
        check("R1 flags", {28'd0, ge_o}, 32'd0);

        // Boundary sweep, each followed by a pick to expose the stored flags.
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    logic [31:0] a, b;
                    if (op[1]) begin
                        a = {hv[i], hv[(i+1)%4]};
                        b = {hv[j], hv[(j+3)%4]};
                    end else begin
                        a = {bv[i], bv[(i+1)%4], bv[(i+2)%4], bv[(i+3)%4]};
                        b = {bv[j], bv[(j+2)%4], bv[(j+1)%4], bv[(j+3)%4]};
                    end
                    run_op(4'(op), a, b);
                    run_op(4'd8, 32'hA1A2_A3A4, 32'hB1B2_B3B4);
                end
            end
        end

        // Direct flag load, then pick and idle behaviour.
        run_op(4'd9, 32'hFFFF_FFF5, 32'h0);
        run_op(4'd8, 32'h1122_3344, 32'h5566_7788);
        run_op(4'd9, 32'h0000_000A, 32'hFFFF_FFFF);
        run_op(4'd8, 32'h1122_3344, 32'h5566_7788);
        idle_op(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        idle_op(4'd9, 32'h0000_0003, 32'h0);
        run_op(4'd12, 32'hFFFF_FFFF, 32'h0101_0101);
        run_op(4'd15, 32'h0000_000F, 32'h0);
        run_op(4'd10, 32'h1234_5678, 32'h8765_4321);

        // Pseudo-random operands over all arithmetic codes.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a, b;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            a = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            b = seed;
            run_op(4'(n % 8), a, b);
            if (n % 3 == 0) run_op(4'd8, b, a);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule